// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core that runs in several operating modes. A 5-bit mode input picks the view in force: at any moment sixteen logical general registers (index 0 to 15) and one current status word are visible. Each logical index is steered to a physical slot according to that mode, so an exception handler gets a private stack pointer and return-address register without saving the interrupted code's copies.

The fast-interrupt mode has private copies of indices 8 through 14. Four other exception modes have private copies of indices 13 and 14 only. User and system modes share the base bank. Index 15, the program counter, is one physical register common to all modes. In total the file holds thirty general-purpose slots and the program counter. It also holds a current status word and five saved status words, one for each exception mode. The saved word is addressed implicitly by the current mode.

The core drives two combinational read ports and one clocked write port, all indexed logically. The current status word and the saved status word each have their own write enable and their own read output.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register reads 0 in every mode, every saved status word reads 0, and the current status output reads 32'h0000_0013 (supervisor).
- R2: Logical indices 0 to 7 are one physical set shared by all modes: a value written in any mode reads back identically in every mode.
- R3: Indices 8 to 12 read a private set only in fast-interrupt mode (5'b10001). Every other mode reads the base set.
- R4: Indices 13 and 14 are private to each of the banks fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111 and undefined 11011. User 10000 and system 11111 share one copy.
- R5: Index 15 is one program-counter register shared by every mode.
- R6: A mode input that is none of the seven listed encodings maps registers exactly as user mode does.
- R7: Reads are combinational. A write lands on the rising edge and uses the mode present at that edge. A read of the slot being written in that same cycle returns the old value.
- R8: The two read ports are independent: different indices read at once each return their own slot's value.
- R9: Each of the five exception modes has its own saved status word. It is written with the saved-status write enable and read on the saved-status output while that mode is current.
- R10: In user, system or unlisted modes the saved-status output reads 0 and a saved-status write changes no saved word.
- R11: A current-status write takes effect on the rising edge and appears on the current-status output after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current operating mode encoding |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| stat_we | input | 1 | Current status write enable |
| stat_wdata | input | 32 | Current status write data |
| stat_rdata | output | 32 | Current status word |
| saved_we | input | 1 | Saved status write enable (current mode's word) |
| saved_wdata | input | 32 | Saved status write data |
| saved_rdata | output | 32 | Saved status word of the current mode, or 0 |

## Verification
A wrong mapping inside the file shows up at the read ports as a value that leaks between modes. A handler sees another mode's stack pointer, or a shared register disagrees between two modes. It appears in the same cycle the mode input changes, because reads are combinational. A write that lands in the wrong slot stays hidden until the victim index is read in its owning mode. For that reason each private copy is given a distinct value and then read under every mode encoding, including unlisted ones. Blocked saved-status writes are exposed by reading every exception mode's saved word after the attempt.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int LIDX_W    = 4;
  localparam int MODE_W    = 5;
  localparam int NUM_PHYS  = 31;
  localparam int PIDX_W    = $clog2(NUM_PHYS);
  localparam int NUM_SAVED = 5;
  localparam int SIDX_W    = $clog2(NUM_SAVED);

  localparam logic [MODE_W-1:0] MD_USER  = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FAST  = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ   = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC   = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT   = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND   = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS   = 5'b11111;

  typedef enum logic [2:0] {
    BK_BASE = 3'd0,
    BK_FAST = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5
  } bank_e;

  // Mode encoding to register bank; unknown encodings fall to the base bank.
  function automatic bank_e mode_to_bank(logic [MODE_W-1:0] m);
    case (m)
      MD_FAST: return BK_FAST;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_BASE;
    endcase
  endfunction

  // Physical layout: 0..14 base, 15 pc, 16..22 fast 8..14,
  // 23..30 two slots per remaining exception bank.
  function automatic logic [PIDX_W-1:0] phys_index(bank_e b, logic [LIDX_W-1:0] li);
    logic [PIDX_W-1:0] li_w;
    logic [PIDX_W-1:0] bk_w;
    li_w = {1'b0, li};
    bk_w = {2'b00, b};
    if (li == 4'd15)
      return 5'd15;
    else if (b == BK_FAST && li >= 4'd8)
      return li_w + 5'd8;
    else if (b != BK_BASE && b != BK_FAST && li >= 4'd13)
      return 5'd19 + (bk_w << 1) + (li_w - 5'd13);
    else
      return li_w;
  endfunction

  function automatic logic [SIDX_W-1:0] saved_index(bank_e b);
    logic [2:0] s;
    s = 3'(b) - 3'd1;
    return s;
  endfunction

endpackage

// File: rtl/bankrf_mode_decode.sv
module bankrf_mode_decode
  import bankrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              has_saved_o
);

  assign bank_o      = mode_to_bank(mode_i);
  assign has_saved_o = (bank_o != BK_BASE);

  always_comb begin
    if (mode_i == MD_USER || mode_i == MD_SYS)
      assert_user_sys_base_R4: assert (bank_o == BK_BASE);
    if (mode_i == MD_FAST)
      assert_fast_bank_R3: assert (bank_o == BK_FAST && has_saved_o);
  end

endmodule

// File: rtl/bankrf_index_map.sv
module bankrf_index_map
  import bankrf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [LIDX_W-1:0] lidx_i,
  output logic [PIDX_W-1:0] pidx_o
);

  assign pidx_o = phys_index(bank_i, lidx_i);

  always_comb begin
    assert_pidx_range_R4: assert (pidx_o < PIDX_W'(NUM_PHYS));
    if (lidx_i < 4'd8)
      assert_low_shared_R2: assert (pidx_o == {1'b0, lidx_i});
    if (lidx_i == 4'd15)
      assert_pc_shared_R5: assert (pidx_o == 5'd15);
    if (bank_i != BK_FAST && lidx_i < 4'd13)
      assert_mid_shared_R3: assert (pidx_o == {1'b0, lidx_i});
  end

endmodule

// File: rtl/bankrf_gpr_array.sv
module bankrf_gpr_array
  import bankrf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] rd_a_pidx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [PIDX_W-1:0] rd_b_pidx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_pidx,
  input  logic [XLEN-1:0]   wr_data
);

  logic [XLEN-1:0] slot_q [NUM_PHYS];
  logic [NUM_PHYS-1:0] slot_hit;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_slot
    assign slot_hit[g] = wr_en && (wr_pidx == PIDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (slot_hit[g])
        slot_q[g] <= wr_data;
    end
  end

  assign rd_a_data = slot_q[rd_a_pidx];
  assign rd_b_data = slot_q[rd_b_pidx];

  assert_one_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_q[$past(wr_pidx)] == $past(wr_data));
  assert_pc_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_pidx == 5'd15) |=> $stable(slot_q[15]));

endmodule

// File: rtl/bankrf_status_regs.sv
module bankrf_status_regs
  import bankrf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [MODE_W-1:0] RESET_MODE = MD_SVC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           bank_i,
  input  logic            has_saved_i,
  input  logic            stat_we,
  input  logic [XLEN-1:0] stat_wdata,
  output logic [XLEN-1:0] stat_rdata,
  input  logic            saved_we,
  input  logic [XLEN-1:0] saved_wdata,
  output logic [XLEN-1:0] saved_rdata
);

  localparam logic [XLEN-1:0] STAT_RESET = XLEN'(RESET_MODE);

  logic [XLEN-1:0] cur_q;
  logic [XLEN-1:0] saved_q [NUM_SAVED];
  logic [SIDX_W-1:0] sel;
  logic [NUM_SAVED*XLEN-1:0] saved_flat;
  logic saved_write_blocked;

  assign sel = saved_index(bank_i);
  assign saved_write_blocked = saved_we && !has_saved_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_q <= STAT_RESET;
    else if (stat_we)
      cur_q <= stat_wdata;
  end

  for (genvar g = 0; g < NUM_SAVED; g++) begin : g_saved
    assign saved_flat[g*XLEN +: XLEN] = saved_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n)
        saved_q[g] <= '0;
      else if (saved_we && has_saved_i && sel == SIDX_W'(g))
        saved_q[g] <= saved_wdata;
    end
  end

  assign stat_rdata  = cur_q;
  assign saved_rdata = has_saved_i ? saved_q[sel] : '0;

  assert_blocked_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    saved_write_blocked |=> $stable(saved_flat));
  assert_status_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> stat_rdata == $past(stat_wdata));
  assert_saved_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (saved_we && has_saved_i) |=> saved_q[$past(sel)] == $past(saved_wdata));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              stat_we,
  input  logic [XLEN-1:0]   stat_wdata,
  output logic [XLEN-1:0]   stat_rdata,
  input  logic              saved_we,
  input  logic [XLEN-1:0]   saved_wdata,
  output logic [XLEN-1:0]   saved_rdata
);

  localparam int NPORT = 3;

  bank_e bank;
  logic  has_saved;
  logic [LIDX_W-1:0] lidx [NPORT];
  logic [PIDX_W-1:0] pidx [NPORT];

  assign lidx[0] = rd_a_idx;
  assign lidx[1] = rd_b_idx;
  assign lidx[2] = wr_idx;

  bankrf_mode_decode u_dec (
    .mode_i      (mode_i),
    .bank_o      (bank),
    .has_saved_o (has_saved)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bankrf_index_map u_map (
      .bank_i (bank),
      .lidx_i (lidx[p]),
      .pidx_o (pidx[p])
    );
  end

  bankrf_gpr_array #(.XLEN(XLEN)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_pidx (pidx[0]),
    .rd_a_data (rd_a_data),
    .rd_b_pidx (pidx[1]),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_pidx   (pidx[2]),
    .wr_data   (wr_data)
  );

  bankrf_status_regs #(.XLEN(XLEN)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_i      (bank),
    .has_saved_i (has_saved),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .stat_rdata  (stat_rdata),
    .saved_we    (saved_we),
    .saved_wdata (saved_wdata),
    .saved_rdata (saved_rdata)
  );

  assert_same_idx_ports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
  assert_no_saved_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_USER || mode_i == MD_SYS) |-> saved_rdata == '0);
  assert_reset_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> stat_rdata == 32'h13);

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, stat_we = 1'b0, saved_we = 1'b0;
  logic [31:0] stat_wdata = '0, stat_rdata, saved_wdata = '0, saved_rdata;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [4:0] U = 5'b10000, F = 5'b10001, I = 5'b10010,
                         S = 5'b10011, A = 5'b10111, D = 5'b11011, Y = 5'b11111;
  logic [4:0] modes [7] = '{U, F, I, S, A, D, Y};
  logic [4:0] exc   [5] = '{F, I, S, A, D};

  always #10 clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    mode_i = m; wr_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] idx, output logic [31:0] d);
    mode_i = m; rd_a_idx = idx;
    #1 d = rd_a_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int k = 0; k < 7; k++)
      for (int j = 0; j < 16; j++) begin
        rd(modes[k], 4'(j), v);
        check("R1 reg", v, 32'h0);
      end
    for (int k = 0; k < 5; k++) begin
      mode_i = exc[k]; #1 check("R1 saved", saved_rdata, 32'h0);
    end
    check("R1 status", stat_rdata, 32'h0000_0013);
  endtask

  task automatic t_private_sp;
    logic [31:0] v;
    for (int k = 0; k < 7; k++) begin
      if (modes[k] == Y) continue;
      wr(modes[k], 4'd13, 32'hA000_0000 | 32'(k));
      wr(modes[k], 4'd14, 32'hB000_0000 | 32'(k));
    end
    for (int k = 0; k < 7; k++) begin
      int own = (modes[k] == Y) ? 0 : k;
      rd(modes[k], 4'd13, v); check("R4 idx13", v, 32'hA000_0000 | 32'(own));
      rd(modes[k], 4'd14, v); check("R4 idx14", v, 32'hB000_0000 | 32'(own));
    end
  endtask

  task automatic t_shared_low;
    logic [31:0] v;
    for (int j = 0; j < 8; j++) wr(I, 4'(j), 32'h1100_0000 + 32'(j));
    for (int k = 0; k < 7; k++)
      for (int j = 0; j < 8; j++) begin
        rd(modes[k], 4'(j), v); check("R2 shared", v, 32'h1100_0000 + 32'(j));
      end
  endtask

  task automatic t_fast_bank;
    logic [31:0] v;
    for (int j = 8; j < 13; j++) begin
      wr(U, 4'(j), 32'hC000_0000 + 32'(j));
      wr(F, 4'(j), 32'hD000_0000 + 32'(j));
    end
    for (int k = 0; k < 7; k++)
      for (int j = 8; j < 13; j++) begin
        rd(modes[k], 4'(j), v);
        check("R3 mid", v, (modes[k] == F ? 32'hD000_0000 : 32'hC000_0000) + 32'(j));
      end
  endtask

  task automatic t_pc;
    logic [31:0] v;
    wr(A, 4'd15, 32'h0000_8004);
    for (int k = 0; k < 7; k++) begin
      rd(modes[k], 4'd15, v); check("R5 pc", v, 32'h0000_8004);
    end
  endtask

  task automatic t_unlisted;
    logic [31:0] v;
    rd(5'b00101, 4'd13, v); check("R6 unlisted rd", v, 32'hA000_0000);
    rd(5'b11100, 4'd9, v);  check("R6 unlisted mid", v, 32'hC000_0009);
    wr(5'b01110, 4'd14, 32'h5A5A_0E0E);
    rd(U, 4'd14, v); check("R6 unlisted wr", v, 32'h5A5A_0E0E);
    rd(F, 4'd14, v); check("R6 fast kept", v, 32'hB000_0001);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    @(negedge clk);
    mode_i = S; rd_a_idx = 4'd13; rd_b_idx = 4'd3;
    wr_idx = 4'd13; wr_data = 32'h7777_0013; wr_en = 1'b1;
    #1 check("R7 old value", rd_a_data, 32'hA000_0003);
    check("R8 port b", rd_b_data, 32'h1100_0003);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R7 new value", rd_a_data, 32'h7777_0013);
    rd(D, 4'd13, v); check("R7 edge mode", v, 32'hA000_0005);
    mode_i = F; rd_a_idx = 4'd10; rd_b_idx = 4'd10;
    #1 check("R8 both ports", rd_b_data, 32'hD000_000A);
    check("R8 port a", rd_a_data, 32'hD000_000A);
  endtask

  task automatic t_saved;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      mode_i = exc[k]; saved_wdata = 32'hE000_0000 | 32'(k); saved_we = 1'b1;
      @(negedge clk);
      saved_we = 1'b0;
    end
    for (int k = 0; k < 5; k++) begin
      mode_i = exc[k]; #1 check("R9 saved", saved_rdata, 32'hE000_0000 | 32'(k));
    end
  endtask

  task automatic t_saved_blocked;
    logic [4:0] bl [3] = '{U, Y, 5'b00000};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      mode_i = bl[k]; saved_wdata = 32'hDEAD_BEEF; saved_we = 1'b1;
      #1 check("R10 reads zero", saved_rdata, 32'h0);
      @(negedge clk);
      saved_we = 1'b0;
      #1 check("R10 still zero", saved_rdata, 32'h0);
    end
    for (int k = 0; k < 5; k++) begin
      mode_i = exc[k]; #1 check("R10 untouched", saved_rdata, 32'hE000_0000 | 32'(k));
    end
  endtask

  task automatic t_status;
    @(negedge clk);
    stat_wdata = 32'h0000_001F; stat_we = 1'b1;
    #1 check("R11 before edge", stat_rdata, 32'h0000_0013);
    @(negedge clk);
    stat_we = 1'b0;
    #1 check("R11 after edge", stat_rdata, 32'h0000_001F);
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_run, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_private_sp();
    t_shared_low();
    t_fast_bank();
    t_pc();
    t_unlisted();
    t_timing();
    t_saved();
    t_saved_blocked();
    t_status();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule